// File: doc/BRIEF.md
# Unaligned Word Load Byte Merger

This block serves the load path of a processor that lets software build a 32-bit value from a byte address that is not a multiple of four. It does this with two partial loads. One is a left-side load, which fills the upper register lanes. The other is a right-side load, which fills the lower lanes. A plain word load is also supported, and it reports a fault when its address is misaligned. Memory is big-endian: byte 0 of a word sits in the most significant lane.

For every request, the block drops the two low address bits and presents the result as a word address to a memory port. It takes back the single aligned word that holds the addressed byte, so no access ever crosses into the neighbouring word. It then combines the selected bytes of that word with the current destination register value, which the caller supplies. Register bytes that the operation does not cover keep their old contents. The merged value and a fault flag are registered and appear one cycle after the request.

Top module: `ualign_merge`

## Requirements
- R1: While reset is asserted, and until the first request completes, res_valid, res_fault and res_data are all zero.
- R2: A request with req_valid high produces res_valid high on the next clock edge only. When req_valid is low, the next cycle shows res_valid low and res_data and res_fault unchanged.
- R3: mem_word_addr equals req_addr with its two low bits removed, so the fetched word always contains the addressed byte.
- R4: A plain load (req_op 2'b00) whose address ends in 2'b00 returns mem_rdata unchanged and res_fault low.
- R5: A plain load whose two low address bits are nonzero sets res_fault high and returns req_reg unchanged.
- R6: A left load (req_op 2'b01) at byte offset k (the two low address bits) places word bytes k..3 into register lanes 0..3-k, counting lane 0 as the most significant lane (bits 31:24). This equals the word shifted left by 8*k bits. The low k lanes keep req_reg.
- R7: A right load (req_op 2'b10) at byte offset k places word bytes 0..k into the low k+1 lanes, right-aligned. This equals the word shifted right by 8*(3-k) bits. The upper 3-k lanes keep req_reg.
- R8: A left load at byte address 3, followed on the next cycle by a right load at byte address 6 that uses the first result as its register input, leaves bytes 3, 4, 5, 6 in the register from most to least significant.
- R9: req_op 2'b11 is a no-operation: the result equals req_reg and res_fault is low.
- R10: Left and right loads never raise res_fault, whatever their offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 00 plain, 01 left, 10 right, 11 no-op |
| req_addr | input | ADDR_W | Byte address of the request |
| req_reg | input | WORD_W | Current destination register value |
| mem_word_addr | output | ADDR_W-2 | Word address of the aligned word to fetch |
| mem_rdata | input | WORD_W | Aligned memory word at mem_word_addr, same cycle |
| res_valid | output | 1 | res_data and res_fault hold a new result |
| res_data | output | WORD_W | Merged register value |
| res_fault | output | 1 | Misaligned plain load |

## Verification
Two events can fall in the same cycle: a result is presented, and a new request is accepted whose register input is that very result. This is how a left load and a right load chain together. The bench provokes the case by issuing the two halves back to back, with req_reg wired combinationally to res_data for the second request. It judges the final register against bytes 3, 4, 5, 6 and the intermediate value against a left-only merge. The byte-lane formulas are also checked at every offset for both partial loads, and misaligned plain loads are checked against an unchanged register.

// File: rtl/ualign_merge.sv
module ualign_merge #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_reg,
  output logic [ADDR_W-3:0] mem_word_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data,
  output logic              res_fault
);
  localparam int LANES = WORD_W / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam logic [1:0] OP_PLAIN = 2'b00;
  localparam logic [1:0] OP_LEFT  = 2'b01;
  localparam logic [1:0] OP_RIGHT = 2'b10;

  logic [OFS_W-1:0]  ofs;
  logic [7:0]        wbyte [LANES];
  logic [WORD_W-1:0] merged;
  logic              fault;

  assign ofs           = req_addr[OFS_W-1:0];
  assign mem_word_addr = req_addr[ADDR_W-1:OFS_W];
  assign fault         = (req_op == OP_PLAIN) && (ofs != '0);

  for (genvar j = 0; j < LANES; j++) begin : g_bytes
    assign wbyte[j] = mem_rdata[WORD_W-1-8*j -: 8];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] old_b;
    logic [7:0] new_b;
    int         src;
    assign old_b = req_reg[WORD_W-1-8*i -: 8];
    always_comb begin
      new_b = old_b;
      src   = 0;
      case (req_op)
        OP_PLAIN: if (ofs == '0) new_b = wbyte[i];
        OP_LEFT: begin
          src = i + int'(ofs);
          if (src < LANES) new_b = wbyte[src[OFS_W-1:0]];
        end
        OP_RIGHT: begin
          src = i + int'(ofs) - (LANES - 1);
          if (src >= 0) new_b = wbyte[src[OFS_W-1:0]];
        end
        default: new_b = old_b;
      endcase
    end
    assign merged[WORD_W-1-8*i -: 8] = new_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_data  <= merged;
        res_fault <= fault;
      end
    end
  end
endmodule

// File: rtl/ualign_merge_chk.sv
module ualign_merge_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [WORD_W-1:0] req_reg,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_data,
  input logic              res_fault
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && $stable(res_data) && $stable(res_fault)));
  p_fault_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b00 && req_addr[1:0] != 2'b00)
      |=> (res_fault && res_data == $past(req_reg)));
  p_plain_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b00 && req_addr[1:0] == 2'b00)
      |=> (!res_fault && res_data == $past(mem_rdata)));
  p_partial_nofault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 2'b01 || req_op == 2'b10)) |=> !res_fault);
  p_left_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01 && req_addr[1:0] == 2'b00)
      |=> res_data == $past(mem_rdata));
  p_right_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b10 && req_addr[1:0] == 2'b11)
      |=> res_data == $past(mem_rdata));
  p_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> (!res_fault && res_data == $past(req_reg)));
endmodule

bind ualign_merge ualign_merge_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .req_reg(req_reg), .mem_rdata(mem_rdata),
  .res_valid(res_valid), .res_data(res_data), .res_fault(res_fault));

// File: tb/sim_ualign_merge.sv
module sim_ualign_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] old_drv = '0;
  logic        chain = 1'b0;
  logic [31:0] req_reg;
  logic [29:0] mem_word_addr;
  logic [31:0] mem_rdata;
  logic        res_valid, res_fault;
  logic [31:0] res_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign req_reg = chain ? res_data : old_drv;

  always_comb
    for (int i = 0; i < 4; i++)
      mem_rdata[31-8*i -: 8] = 8'(32'(mem_word_addr) * 4 + i + 16);

  ualign_merge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_reg(req_reg), .mem_word_addr(mem_word_addr),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_data(res_data),
    .res_fault(res_fault));

  // {op, addr, expected data, expected fault}; register input C0C1C2C3, byte b holds 10h+b
  localparam logic [42:0] VEC [13] = '{
    {2'b00, 8'd0, 32'h10111213, 1'b0},
    {2'b00, 8'd4, 32'h14151617, 1'b0},
    {2'b00, 8'd5, 32'hC0C1C2C3, 1'b1},
    {2'b00, 8'd2, 32'hC0C1C2C3, 1'b1},
    {2'b01, 8'd4, 32'h14151617, 1'b0},
    {2'b01, 8'd5, 32'h151617C3, 1'b0},
    {2'b01, 8'd6, 32'h1617C2C3, 1'b0},
    {2'b01, 8'd7, 32'h17C1C2C3, 1'b0},
    {2'b10, 8'd4, 32'hC0C1C214, 1'b0},
    {2'b10, 8'd5, 32'hC0C11415, 1'b0},
    {2'b10, 8'd6, 32'hC0141516, 1'b0},
    {2'b10, 8'd7, 32'h14151617, 1'b0},
    {2'b11, 8'd5, 32'hC0C1C2C3, 1'b0}
  };

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {res_valid, res_data}, 33'h0);
    chk("R1 reset fault", {32'h0, res_fault}, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {res_valid, res_data}, 33'h0);

    for (int n = 0; n < 13; n++) begin
      req_op    = VEC[n][42:41];
      req_addr  = {24'h0, VEC[n][40:33]};
      old_drv   = 32'hC0C1C2C3;
      req_valid = 1'b1;
      #1;
      chk("R3 word address", {3'b0, mem_word_addr}, {3'b0, req_addr[31:2]});
      @(negedge clk);
      req_valid = 1'b0;
      // R4 R5 R6 R7 R9 R10 by opcode
      chk($sformatf("R4-7/R9 data vec %0d", n), {1'b0, res_data}, {1'b0, VEC[n][32:1]});
      chk($sformatf("R5/R10 fault vec %0d", n), {32'h0, res_fault}, {32'h0, VEC[n][0]});
      chk("R2 valid one cycle later", {32'h0, res_valid}, 33'h1);
    end

    @(negedge clk);
    chk("R2 valid drops when idle", {32'h0, res_valid}, 33'h0);
    chk("R2 data held when idle", {1'b0, res_data}, {1'b0, 32'hC0C1C2C3});

    old_drv = 32'hAAAAAAAA;
    req_op = 2'b01; req_addr = 32'd3; req_valid = 1'b1;
    @(negedge clk);
    chk("R8 left half", {1'b0, res_data}, {1'b0, 32'h13AAAAAA});
    chain = 1'b1; req_op = 2'b10; req_addr = 32'd6;
    @(negedge clk);
    req_valid = 1'b0; chain = 1'b0;
    chk("R8 joined word", {1'b0, res_data}, {1'b0, 32'h13141516});
    chk("R8 valid", {32'h0, res_valid}, 33'h1);

    req_op = 2'b00; req_addr = 32'd9; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 misaligned keeps register", {res_fault, res_data}, {1'b1, 32'hAAAAAAAA});

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears result", {res_valid, res_data}, 33'h0);
    summary();
  end
endmodule